// File: doc/BRIEF.md
# Multi-mode macrocell register

This block is the storage element of one programmable-logic cell. Static configuration inputs decide what the element is: a D, toggle, JK or set/reset flip-flop, or a transparent latch. The same inputs also choose where its data comes from, which clock drives it, whether a clock-enable term gates that clock, and which signals clear or preset it asynchronously. While the chip runs, the configuration inputs are held constant. The signal inputs are the cell's combining-gate result, a dedicated data term, the pad input, three global clocks, a clock term, a global clear and several control terms.

Two outputs leave the cell. The cell output drives toward the pad. The buried feedback signal returns to the routing fabric. Each one selects, on its own, either the stored value or the combinational value (the combining-gate result). This lets a cell drive a combinational pin while it still feeds a registered value back, or the other way round.

Top module: `mcell_reg`

## Requirements
- R1: `cfg_dsrc` picks the primary data input: 0 selects `xor_in`, 1 selects `dat_pt`, 2 selects `pad_in`.
- R2: With `cfg_mode`=0 (D), a qualifying clock edge stores the primary data. With `cfg_mode`=1 (toggle), an edge inverts the stored value when the primary data is 1 and keeps it when the data is 0.
- R3: With `cfg_mode`=2 (JK, J = primary data, K = `k_pt`), J=1 K=0 sets, J=0 K=1 clears, J=K=0 holds and J=K=1 inverts. With `cfg_mode`=3 (set/reset, S = primary data, R = `k_pt`), S=1 R=0 sets, S=0 R=1 clears, and both 0 or both 1 hold.
- R4: With `cfg_mode`=4 (latch), the stored value follows the primary data while the selected clock is high and the enable qualifies. It holds while the clock is low.
- R5: `cfg_clksel` 0 to 2 selects `gclk[0]` to `gclk[2]`, and 3 selects `clk_pt`. Only a rising edge of the selected clock updates the flip-flop.
- R6: With a global clock selected and `cfg_ce_use`=1, edges are ignored while `ce_pt` is 0. When `clk_pt` is the clock, `ce_pt` has no effect.
- R7: `cfg_clrsel` sets the asynchronous clear source: 0 never, 1 `gclr`, 2 `clr_pt`, 3 either one. An active clear forces the stored value to 0 without a clock.
- R8: With `cfg_pre_use`=1, `pre_pt` forces the stored value to 1 without a clock. With `cfg_pre_use`=0, `pre_pt` has no effect.
- R9: When clear and preset are active together, the stored value is 0.
- R10: `cfg_out_reg`=1 makes `cell_out` the stored value and 0 makes it `xor_in`. `cfg_fb_reg` makes the same choice for `fb_out`, independently of `cfg_out_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_dsrc | input | 2 | Primary data source select |
| cfg_mode | input | 3 | Storage type: 0 D, 1 toggle, 2 JK, 3 set/reset, 4 latch |
| cfg_clksel | input | 2 | Clock select: global 0..2, or 3 for the clock term |
| cfg_ce_use | input | 1 | Use `ce_pt` as clock enable when a global clock is selected |
| cfg_clrsel | input | 2 | Asynchronous clear source select |
| cfg_pre_use | input | 1 | Enable asynchronous preset from `pre_pt` |
| cfg_out_reg | input | 1 | Cell output: 1 stored, 0 combinational |
| cfg_fb_reg | input | 1 | Feedback: 1 stored, 0 combinational |
| xor_in | input | 1 | Combining-gate result |
| dat_pt | input | 1 | Dedicated data product term |
| pad_in | input | 1 | Pad input |
| k_pt | input | 1 | Second data term (K or R) |
| gclk | input | 3 | Global clocks |
| clk_pt | input | 1 | Product-term clock |
| ce_pt | input | 1 | Clock-enable product term |
| gclr | input | 1 | Global asynchronous clear |
| clr_pt | input | 1 | Clear product term |
| pre_pt | input | 1 | Preset product term |
| cell_out | output | 1 | Cell output toward the pad |
| fb_out | output | 1 | Buried feedback |

## Verification
The hardest situations to reach from the ports are those where an input must have no effect. Examples are an edge on an unselected clock, a disabled edge, a clear with the clear source turned off, and an enable that the product-term clock ignores. None of these can be seen unless the stored value first differs from what the ignored event would write. Before each such stimulus, the bench therefore loads the opposite value through the D path. It then reads the stored value back through `cell_out` with `cfg_out_reg` set.

A second difficulty is the latch window. Clocks are driven by tasks one pulse at a time, so the bench can hold the selected clock high, change the data and see it pass through. It can then drop the clock and see the data held.

// File: rtl/mcell_pkg.sv
`timescale 1ns/1ps
package mcell_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    DSRC_XOR = 2'd0,
    DSRC_PT  = 2'd1,
    DSRC_PAD = 2'd2
  } dsrc_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_GLOB = 2'd1,
    CLR_PT   = 2'd2,
    CLR_ANY  = 2'd3
  } clrsel_e;

  // Next stored value for the edge-triggered modes.
  function automatic logic next_q(input logic [2:0] mode, input logic q,
                                  input logic a, input logic b);
    logic r;
    case (mode)
      MODE_D:  r = a;
      MODE_T:  r = q ^ a;
      MODE_JK: r = (a & ~q) | (~b & q);
      MODE_SR: r = (a & ~b) | (q & ~(b & ~a));
      default: r = q;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mcell_srcsel.sv
`timescale 1ns/1ps
module mcell_srcsel #(
  parameter int NGCLK = 3,
  localparam int CSW = $clog2(NGCLK + 1)
) (
  input  logic [1:0]       cfg_dsrc,
  input  logic [CSW-1:0]   cfg_clksel,
  input  logic             cfg_ce_use,
  input  logic [1:0]       cfg_clrsel,
  input  logic             cfg_pre_use,
  input  logic             xor_in,
  input  logic             dat_pt,
  input  logic             pad_in,
  input  logic [NGCLK-1:0] gclk,
  input  logic             clk_pt,
  input  logic             ce_pt,
  input  logic             gclr,
  input  logic             clr_pt,
  input  logic             pre_pt,
  output logic             d_sel,
  output logic             clk_sel,
  output logic             ce_ok,
  output logic             ar,
  output logic             ap
);
  import mcell_pkg::*;

  logic [NGCLK:0] clk_vec;
  logic           use_pt_clk;

  // Clock candidates: global clocks below, the product-term clock on top.
  genvar gi;
  generate
    for (gi = 0; gi < NGCLK; gi++) begin : g_clk
      assign clk_vec[gi] = gclk[gi];
    end
  endgenerate
  assign clk_vec[NGCLK] = clk_pt;

  assign use_pt_clk = (int'(cfg_clksel) >= NGCLK);
  assign clk_sel    = use_pt_clk ? clk_pt : clk_vec[cfg_clksel];
  assign ce_ok      = use_pt_clk | ~cfg_ce_use | ce_pt;

  always_comb begin
    case (dsrc_e'(cfg_dsrc))
      DSRC_PT:  d_sel = dat_pt;
      DSRC_PAD: d_sel = pad_in;
      default:  d_sel = xor_in;
    endcase
  end

  always_comb begin
    case (clrsel_e'(cfg_clrsel))
      CLR_GLOB: ar = gclr;
      CLR_PT:   ar = clr_pt;
      CLR_ANY:  ar = gclr | clr_pt;
      default:  ar = 1'b0;
    endcase
  end

  assign ap = cfg_pre_use & pre_pt;

endmodule

// File: rtl/mcell_store.sv
`timescale 1ns/1ps
module mcell_store (
  input  logic       clk,
  input  logic       ce_ok,
  input  logic       ar,
  input  logic       ap,
  input  logic [2:0] mode,
  input  logic       a,
  input  logic       b,
  output logic       q_ff,
  output logic       q_lat,
  output logic       q
);
  import mcell_pkg::*;

  logic is_latch;
  logic lat_open;

  assign is_latch = (mode == MODE_LATCH);
  assign lat_open = clk & ce_ok;

  // Edge-triggered storage; clear dominates preset.
  always_ff @(posedge clk or posedge ar or posedge ap) begin
    if (ar)
      q_ff <= 1'b0;
    else if (ap)
      q_ff <= 1'b1;
    else if (ce_ok && !is_latch)
      q_ff <= next_q(mode, q_ff, a, b);
  end

  // Flow-through storage: open while the clock is high.
  always_latch begin
    if (ar)
      q_lat <= 1'b0;
    else if (ap)
      q_lat <= 1'b1;
    else if (lat_open)
      q_lat <= a;
  end

  assign q = is_latch ? q_lat : q_ff;

endmodule

// File: rtl/mcell_outsel.sv
`timescale 1ns/1ps
module mcell_outsel (
  input  logic cfg_out_reg,
  input  logic cfg_fb_reg,
  input  logic q,
  input  logic comb,
  output logic cell_out,
  output logic fb_out
);
  assign cell_out = cfg_out_reg ? q : comb;
  assign fb_out   = cfg_fb_reg  ? q : comb;
endmodule

// File: rtl/mcell_reg.sv
`timescale 1ns/1ps
module mcell_reg #(
  parameter int NGCLK = 3,
  localparam int CSW = $clog2(NGCLK + 1)
) (
  input  logic [1:0]       cfg_dsrc,
  input  logic [2:0]       cfg_mode,
  input  logic [CSW-1:0]   cfg_clksel,
  input  logic             cfg_ce_use,
  input  logic [1:0]       cfg_clrsel,
  input  logic             cfg_pre_use,
  input  logic             cfg_out_reg,
  input  logic             cfg_fb_reg,
  input  logic             xor_in,
  input  logic             dat_pt,
  input  logic             pad_in,
  input  logic             k_pt,
  input  logic [NGCLK-1:0] gclk,
  input  logic             clk_pt,
  input  logic             ce_pt,
  input  logic             gclr,
  input  logic             clr_pt,
  input  logic             pre_pt,
  output logic             cell_out,
  output logic             fb_out
);
  // Named internal events, visible to the bound checker.
  logic d_net, clk_net, ce_net, ar_net, ap_net;
  logic q_ff, q_lat, q_net;

  mcell_srcsel #(.NGCLK(NGCLK)) u_src (
    .cfg_dsrc   (cfg_dsrc),
    .cfg_clksel (cfg_clksel),
    .cfg_ce_use (cfg_ce_use),
    .cfg_clrsel (cfg_clrsel),
    .cfg_pre_use(cfg_pre_use),
    .xor_in     (xor_in),
    .dat_pt     (dat_pt),
    .pad_in     (pad_in),
    .gclk       (gclk),
    .clk_pt     (clk_pt),
    .ce_pt      (ce_pt),
    .gclr       (gclr),
    .clr_pt     (clr_pt),
    .pre_pt     (pre_pt),
    .d_sel      (d_net),
    .clk_sel    (clk_net),
    .ce_ok      (ce_net),
    .ar         (ar_net),
    .ap         (ap_net)
  );

  mcell_store u_store (
    .clk  (clk_net),
    .ce_ok(ce_net),
    .ar   (ar_net),
    .ap   (ap_net),
    .mode (cfg_mode),
    .a    (d_net),
    .b    (k_pt),
    .q_ff (q_ff),
    .q_lat(q_lat),
    .q    (q_net)
  );

  mcell_outsel u_out (
    .cfg_out_reg(cfg_out_reg),
    .cfg_fb_reg (cfg_fb_reg),
    .q          (q_net),
    .comb       (xor_in),
    .cell_out   (cell_out),
    .fb_out     (fb_out)
  );

endmodule

// File: rtl/mcell_reg_chk.sv
`timescale 1ns/1ps
module mcell_reg_chk (
  input logic       clk_net,
  input logic       ce_net,
  input logic       ar_net,
  input logic       ap_net,
  input logic       d_net,
  input logic       k_pt,
  input logic [2:0] cfg_mode,
  input logic       cfg_out_reg,
  input logic       cfg_fb_reg,
  input logic       xor_in,
  input logic       q_ff,
  input logic       q_net,
  input logic       cell_out,
  input logic       fb_out
);
  // Marks an asynchronous event between two clock edges.
  logic async_seen;
  logic flop_mode;

  assign flop_mode = (cfg_mode != 3'd4);

  always_ff @(posedge clk_net or posedge ar_net or posedge ap_net) begin
    if (ar_net || ap_net) async_seen <= 1'b1;
    else                  async_seen <= 1'b0;
  end

  assert_t_toggle_R2: assert property (@(posedge clk_net) disable iff (ar_net || ap_net)
    (cfg_mode == 3'd1 && ce_net && d_net) |=> (async_seen || q_ff == !$past(q_ff)));

  assert_jk_toggle_R3: assert property (@(posedge clk_net) disable iff (ar_net || ap_net)
    (cfg_mode == 3'd2 && ce_net && d_net && k_pt) |=> (async_seen || q_ff == !$past(q_ff)));

  assert_sr_hold_R3: assert property (@(posedge clk_net) disable iff (ar_net || ap_net)
    (cfg_mode == 3'd3 && ce_net && d_net && k_pt) |=> (async_seen || $stable(q_ff)));

  assert_ce_hold_R6: assert property (@(posedge clk_net) disable iff (ar_net || ap_net)
    (flop_mode && !ce_net) |=> (async_seen || $stable(q_ff)));

  assert_clear_R7: assert property (@(posedge clk_net) ar_net |-> (q_net == 1'b0));

  assert_preset_R8: assert property (@(posedge clk_net) (ap_net && !ar_net) |-> (q_net == 1'b1));

  assert_reset_wins_R9: assert property (@(posedge clk_net) (ap_net && ar_net) |-> (q_ff == 1'b0));

  assert_out_sel_R10: assert property (@(posedge clk_net)
    cell_out == (cfg_out_reg ? q_net : xor_in));

  assert_fb_sel_R10: assert property (@(posedge clk_net)
    fb_out == (cfg_fb_reg ? q_net : xor_in));

endmodule

bind mcell_reg mcell_reg_chk u_chk (
  .clk_net    (clk_net),
  .ce_net     (ce_net),
  .ar_net     (ar_net),
  .ap_net     (ap_net),
  .d_net      (d_net),
  .k_pt       (k_pt),
  .cfg_mode   (cfg_mode),
  .cfg_out_reg(cfg_out_reg),
  .cfg_fb_reg (cfg_fb_reg),
  .xor_in     (xor_in),
  .q_ff       (q_ff),
  .q_net      (q_net),
  .cell_out   (cell_out),
  .fb_out     (fb_out)
);

// File: tb/sim_mcell_reg.sv
`timescale 1ns/1ps
module sim_mcell_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // Vector fields: {mode[2:0], a, b, expected stored value}
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 1'b0, 1'b1},  // D load 1
    {3'd0, 1'b0, 1'b0, 1'b0},  // D load 0
    {3'd1, 1'b1, 1'b0, 1'b1},  // T toggle
    {3'd1, 1'b0, 1'b0, 1'b1},  // T hold
    {3'd1, 1'b1, 1'b0, 1'b0},  // T toggle
    {3'd2, 1'b1, 1'b0, 1'b1},  // JK set
    {3'd2, 1'b1, 1'b1, 1'b0},  // JK toggle
    {3'd2, 1'b0, 1'b0, 1'b0},  // JK hold
    {3'd3, 1'b1, 1'b0, 1'b1},  // SR set
    {3'd3, 1'b1, 1'b1, 1'b1},  // SR both: hold
    {3'd3, 1'b0, 1'b1, 1'b0},  // SR reset
    {3'd2, 1'b1, 1'b1, 1'b1},  // JK toggle
    {3'd2, 1'b0, 1'b1, 1'b0}   // JK clear
  };

  logic [1:0] cfg_dsrc, cfg_clksel, cfg_clrsel;
  logic [2:0] cfg_mode, gclk;
  logic cfg_ce_use, cfg_pre_use, cfg_out_reg, cfg_fb_reg;
  logic xor_in, dat_pt, pad_in, k_pt, clk_pt, ce_pt, gclr, clr_pt, pre_pt;
  logic cell_out, fb_out;
  int total = 0, bad = 0;
  bit done = 0;

  mcell_reg u0 (.*);

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_g(input int idx);
    gclk[idx] = 1'b1; #(CLK_PERIOD/2);
    gclk[idx] = 1'b0; #(CLK_PERIOD/2);
  endtask

  task automatic pulse_pt();
    clk_pt = 1'b1; #(CLK_PERIOD/2);
    clk_pt = 1'b0; #(CLK_PERIOD/2);
  endtask

  // Load a value through D mode on gclk[0], restoring the mode afterwards.
  task automatic load(input logic v);
    logic [2:0] m; logic [1:0] s, c; logic e;
    m = cfg_mode; s = cfg_dsrc; c = cfg_clksel; e = cfg_ce_use;
    cfg_mode = 3'd0; cfg_dsrc = 2'd0; cfg_clksel = 2'd0; cfg_ce_use = 1'b0;
    xor_in = v; #1; pulse_g(0);
    cfg_mode = m; cfg_dsrc = s; cfg_clksel = c; cfg_ce_use = e; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_dsrc = 0; cfg_mode = 0; cfg_clksel = 0; cfg_ce_use = 0;
    cfg_clrsel = 2'd1; cfg_pre_use = 0; cfg_out_reg = 1; cfg_fb_reg = 1;
    xor_in = 0; dat_pt = 0; pad_in = 0; k_pt = 0; gclk = 0; clk_pt = 0;
    ce_pt = 0; gclr = 1; clr_pt = 0; pre_pt = 0;
    #(CLK_PERIOD);
    check("R7 reset state out", cell_out, 1'b0);
    check("R7 reset state fb", fb_out, 1'b0);
    gclr = 0; #1;

    // Table walk on gclk[0], data from xor_in (R2, R3)
    for (int i = 0; i < NVEC; i++) begin
      cfg_mode = VEC[i][5:3]; xor_in = VEC[i][2]; k_pt = VEC[i][1]; #1;
      pulse_g(0);
      check($sformatf("R2/R3 vector %0d", i), cell_out, VEC[i][0]);
    end

    // R1: data sources
    cfg_mode = 0; xor_in = 0; dat_pt = 1; pad_in = 0; cfg_dsrc = 2'd1; #1;
    pulse_g(0); check("R1 product-term source", cell_out, 1'b1);
    cfg_dsrc = 2'd2; dat_pt = 1; pad_in = 0; #1;
    pulse_g(0); check("R1 pad source", cell_out, 1'b0);
    cfg_dsrc = 2'd0; xor_in = 1; pad_in = 0; dat_pt = 0; #1;
    pulse_g(0); check("R1 xor source", cell_out, 1'b1);

    // R5: clock selection
    load(1'b0); cfg_clksel = 2'd1; xor_in = 1; #1;
    pulse_g(0); pulse_g(2); pulse_pt();
    check("R5 unselected clocks ignored", cell_out, 1'b0);
    pulse_g(1); check("R5 gclk1 edge", cell_out, 1'b1);
    load(1'b0); cfg_clksel = 2'd3; xor_in = 1; #1;
    pulse_g(0); check("R5 global ignored under pt clock", cell_out, 1'b0);
    pulse_pt(); check("R5 product-term clock edge", cell_out, 1'b1);

    // R6: clock enable
    load(1'b0); cfg_clksel = 2'd2; cfg_ce_use = 1; ce_pt = 0; xor_in = 1; #1;
    pulse_g(2); check("R6 disabled edge ignored", cell_out, 1'b0);
    ce_pt = 1; #1; pulse_g(2); check("R6 enabled edge", cell_out, 1'b1);
    load(1'b0); cfg_clksel = 2'd3; cfg_ce_use = 1; ce_pt = 0; xor_in = 1; #1;
    pulse_pt(); check("R6 enable ignored for pt clock", cell_out, 1'b1);
    cfg_ce_use = 0; cfg_clksel = 2'd0; ce_pt = 0; #1;

    // R7: clear sources
    load(1'b1); cfg_clrsel = 2'd0; gclr = 1; clr_pt = 1; #2;
    check("R7 clear disabled", cell_out, 1'b1);
    gclr = 0; clr_pt = 0; cfg_clrsel = 2'd2; #1;
    gclr = 1; #2; check("R7 gclr not selected", cell_out, 1'b1);
    gclr = 0; clr_pt = 1; #2; check("R7 product-term clear", cell_out, 1'b0);
    clr_pt = 0; #1; load(1'b1); cfg_clrsel = 2'd3; gclr = 1; #2;
    check("R7 either: gclr", cell_out, 1'b0);
    gclr = 0; #1; load(1'b1); clr_pt = 1; #2;
    check("R7 either: term", cell_out, 1'b0);
    clr_pt = 0; cfg_clrsel = 2'd1; #1;

    // R8: preset
    load(1'b0); cfg_pre_use = 0; pre_pt = 1; #2;
    check("R8 preset disabled", cell_out, 1'b0);
    pre_pt = 0; cfg_pre_use = 1; #1; pre_pt = 1; #2;
    check("R8 preset active", cell_out, 1'b1);
    pre_pt = 0; #1;

    // R9: clear beats preset
    load(1'b1); gclr = 1; pre_pt = 1; #2;
    check("R9 reset wins", cell_out, 1'b0);
    gclr = 0; pre_pt = 0; cfg_pre_use = 0; #1;

    // R4: latch mode
    cfg_mode = 3'd4; cfg_clksel = 2'd0; xor_in = 0; #1;
    gclk[0] = 1; xor_in = 1; #1;
    check("R4 latch transparent high", cell_out, 1'b1);
    xor_in = 0; #1; check("R4 latch follows", cell_out, 1'b0);
    gclk[0] = 0; #1; xor_in = 1; #1;
    check("R4 latch holds low", cell_out, 1'b0);
    cfg_mode = 3'd0; #1;

    // R10: independent output and feedback selection
    load(1'b1); xor_in = 0; cfg_out_reg = 0; cfg_fb_reg = 1; #1;
    check("R10 out comb", cell_out, 1'b0);
    check("R10 fb registered", fb_out, 1'b1);
    cfg_out_reg = 1; cfg_fb_reg = 0; #1;
    check("R10 out registered", cell_out, 1'b1);
    check("R10 fb comb", fb_out, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule